// File: doc/BRIEF.md
# Steered PWM Output Stage with Dead-Band and Auto-Shutdown

This block sits after a PWM generator and decides what each of four output pins shows. A pin either carries the incoming PWM waveform, after the active level configured for its pin group has been applied, or it carries a bit of a general-purpose port data register. The rising (inactive-to-active) edge of the PWM is delayed by a programmable dead-band count, measured in instruction cycles of four clocks each. The falling edge goes through with no delay. An external shutdown event forces every steered pin to its inactive level. Recovery is either automatic when the event ends or waits for a software clear.

Software changes the per-pin steering mask through a small register write port. A write with the sync flag clear takes effect on the next instruction-cycle tick. A write with the sync flag set is parked in a shadow register and applied at the next PWM period-start strobe. Steering only applies while the mode field selects PWM and the output configuration selects single-output operation. In every other case all four pins show the port data.

Three state machines make up the block. The steering update machine has the states SS_IDLE, SS_WAIT_TICK and SS_WAIT_PERIOD. A steering write moves it to SS_WAIT_TICK or SS_WAIT_PERIOD. A tick or a period strobe then returns it to SS_IDLE and loads the mask. The shutdown machine has the states SD_RUN, SD_HOLD and SD_LATCH. An event moves SD_RUN to SD_HOLD. When the event ends, SD_HOLD goes to SD_RUN if restart is enabled and to SD_LATCH if it is not. SD_LATCH goes to SD_RUN on a clear write, or back to SD_HOLD on a new event. The dead-band machine has the states DB_IDLE, DB_COUNT and DB_ON. A PWM rise moves DB_IDLE to DB_COUNT, or straight to DB_ON when the delay is zero. When the count expires, DB_COUNT goes to DB_ON. Any PWM fall returns either state to DB_IDLE.

Top module: `pwm_steer_unit`

## Requirements
- R1: After reset the steering mask is 4'b0001 (pin 0 only), the sync flag, restart enable, dead-band count, mode, configuration and port data are all 0, so every pin drives 0.
- R2: Register map, written with wr_en. Address 0 holds mode in bits 3:0 and output configuration in bits 5:4. Address 1 holds the steering mask in bits 3:0 and sync in bit 4. Address 2 holds the dead-band count in bits 6:0 and restart enable in bit 7. Address 3 holds port data in bits 3:0. A write of any data to address 4 is a shutdown clear. With steering on, pin i shows the PWM when mask bit i is 1 and port data bit i when it is 0.
- R3: Mode bit 1 set makes pins 0 and 2 active-low. Mode bit 0 set makes pins 1 and 3 active-low. A steered pin drives the active level XOR'ed with its group's active-low bit.
- R4: Unless mode bits 3:2 equal 2'b11 and configuration equals 2'b00, all four pins show port data whatever the mask.
- R5: A steering write with sync 0 changes the pins from the cycle after the next tick. Until then the old mask stays in force.
- R6: A steering write with sync 1 leaves the old mask in force through any ticks. The new mask applies from the cycle after the next period_start.
- R7: With dead-band count D > 0, a steered pin turns active 4*D clock cycles after pwm_in rises. With D = 0 it follows pwm_in in the same cycle.
- R8: A PWM fall deactivates the pin in the same cycle. A PWM high pulse shorter than 4*D cycles never appears on the pins.
- R9: From the cycle after shutdown_evt is sampled high, every steered pin drives its inactive level. Unsteered pins keep showing port data.
- R10: With restart enable 1, the PWM reappears on the cycle after shutdown_evt is sampled low.
- R11: With restart enable 0, shutdown persists after the event ends until a write to address 4. A clear written while the event is still high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Instruction-cycle enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_in | input | 1 | Raw PWM waveform, 1 = active |
| period_start | input | 1 | PWM period-start strobe |
| shutdown_evt | input | 1 | Shutdown event, level sensitive |
| pin_out | output | 4 | Output pins |

## Verification
The assertions assume that the dead-band count is only rewritten while pwm_in is low. A count loaded into a running delay is kept, so rewriting it mid-count would make the delay ambiguous. They also assume that a steering write arriving in the same cycle as a tick or period strobe takes precedence and restarts the wait. The random stimulus only issues address-2 writes in cycles where pwm_in is 0, and its reference model applies write-over-strobe precedence. Apart from that, it mixes writes, ticks, strobes and shutdown bursts freely.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
    localparam int NUM_PINS  = 4;
    localparam int DLY_W     = 7;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STEER = 3'd1;
    localparam logic [ADDR_W-1:0] A_DBAND = 3'd2;
    localparam logic [ADDR_W-1:0] A_PORT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLEAR = 3'd4;

    typedef enum logic [1:0] {SS_IDLE, SS_WAIT_TICK, SS_WAIT_PERIOD} steer_state_t;
    typedef enum logic [1:0] {SD_RUN, SD_HOLD, SD_LATCH} sd_state_t;
    typedef enum logic [1:0] {DB_IDLE, DB_COUNT, DB_ON} db_state_t;
endpackage

// File: rtl/steer_sync_fsm.sv
module steer_sync_fsm
    import pwm_steer_pkg::*;
#(
    parameter int                 N_PINS     = 4,
    parameter logic [N_PINS-1:0]  RESET_MASK = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              period_start,
    input  logic              wr_steer,
    input  logic [N_PINS-1:0] wr_mask,
    input  logic              wr_sync,
    output logic [N_PINS-1:0] steer_act
);
    steer_state_t      state, state_n;
    logic [N_PINS-1:0] shadow;
    logic              load;

    always_comb begin
        state_n = state;
        load    = 1'b0;
        if (wr_steer) begin
            state_n = wr_sync ? SS_WAIT_PERIOD : SS_WAIT_TICK;
        end else begin
            unique case (state)
                SS_IDLE:        state_n = SS_IDLE;
                SS_WAIT_TICK:   if (tick)         begin state_n = SS_IDLE; load = 1'b1; end
                SS_WAIT_PERIOD: if (period_start) begin state_n = SS_IDLE; load = 1'b1; end
                default:        state_n = SS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SS_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow    <= RESET_MASK;
            steer_act <= RESET_MASK;
        end else begin
            if (wr_steer) shadow    <= wr_mask;
            if (load)     steer_act <= shadow;
        end
    end

    // R6
    hold_for_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_WAIT_PERIOD && !period_start && !wr_steer) |=> $stable(steer_act));
endmodule

// File: rtl/shutdown_fsm.sv
module shutdown_fsm
    import pwm_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic restart_en,
    input  logic clr,
    output logic sd_flag
);
    sd_state_t state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            SD_RUN:   if (evt) state_n = SD_HOLD;
            SD_HOLD:  if (!evt) state_n = restart_en ? SD_RUN : SD_LATCH;
            SD_LATCH: if (evt) state_n = SD_HOLD;
                      else if (clr) state_n = SD_RUN;
            default:  state_n = SD_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SD_RUN;
        else        state <= state_n;
    end

    always_comb sd_flag = (state != SD_RUN);

    // R9
    evt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sd_flag);
    // R10
    auto_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_en && state == SD_HOLD && !evt) |=> !sd_flag);
    // R11
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SD_LATCH && !evt && !clr) |=> sd_flag);
endmodule

// File: rtl/deadband_delay.sv
module deadband_delay
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [CNT_W-1:0] dly,
    output logic             pwm_out
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    db_state_t        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [PRE_W-1:0] pre, pre_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        pre_n   = pre;
        unique case (state)
            DB_IDLE: if (pwm_in) begin
                state_n = (dly == '0) ? DB_ON : DB_COUNT;
                cnt_n   = dly;
                pre_n   = PRE_W'(1);
            end
            DB_COUNT: if (!pwm_in) begin
                state_n = DB_IDLE;
            end else begin
                pre_n = pre + PRE_W'(1);
                if (pre == PRE_LAST) begin
                    if (cnt == CNT_ONE) state_n = DB_ON;
                    else                cnt_n   = cnt - CNT_ONE;
                end
            end
            DB_ON:   if (!pwm_in) state_n = DB_IDLE;
            default: state_n = DB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DB_IDLE;
            cnt   <= '0;
            pre   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pre   <= pre_n;
        end
    end

    always_comb pwm_out = pwm_in & ((state == DB_ON) | ((state == DB_IDLE) & (dly == '0)));

    // R7
    rise_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly != '0 && $rose(pwm_in)) |-> !pwm_out);
    // R8
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DB_COUNT) |-> (cnt != '0));
endmodule

// File: rtl/pwm_steer_unit.sv
module pwm_steer_unit
    import pwm_steer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                pwm_in,
    input  logic                period_start,
    input  logic                shutdown_evt,
    output logic [NUM_PINS-1:0] pin_out
);
    logic [3:0]          mode_q;
    logic [1:0]          cfg_q;
    logic [DLY_W-1:0]    dly_q;
    logic                restart_q;
    logic [NUM_PINS-1:0] port_q;
    logic [NUM_PINS-1:0] steer_act;
    logic                sd_flag, pwm_dly, pwm_live, steer_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            cfg_q     <= '0;
            dly_q     <= '0;
            restart_q <= 1'b0;
            port_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  begin mode_q <= wr_data[3:0]; cfg_q <= wr_data[5:4]; end
                A_DBAND: begin dly_q <= wr_data[DLY_W-1:0]; restart_q <= wr_data[7]; end
                A_PORT:  port_q <= wr_data[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    steer_sync_fsm #(.N_PINS(NUM_PINS), .RESET_MASK(4'b0001)) u_steer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period_start(period_start),
        .wr_steer(wr_en && wr_addr == A_STEER), .wr_mask(wr_data[NUM_PINS-1:0]),
        .wr_sync(wr_data[4]), .steer_act(steer_act));

    shutdown_fsm u_sd (
        .clk(clk), .rst_n(rst_n), .evt(shutdown_evt), .restart_en(restart_q),
        .clr(wr_en && wr_addr == A_CLEAR), .sd_flag(sd_flag));

    deadband_delay #(.CNT_W(DLY_W), .PRE_W(2)) u_db (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dly(dly_q), .pwm_out(pwm_dly));

    always_comb begin
        steer_on = (mode_q[3:2] == 2'b11) && (cfg_q == 2'b00);
        pwm_live = pwm_dly & ~sd_flag;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic low_act;
        assign low_act    = (i % 2 == 0) ? mode_q[1] : mode_q[0];
        assign pin_out[i] = (steer_on & steer_act[i]) ? (pwm_live ^ low_act) : port_q[i];

        // R9
        sd_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sd_flag && steer_on && steer_act[i]) |-> (pin_out[i] == low_act));
    end
endmodule

// File: tb/tb_pwm_steer_unit.sv
module tb_pwm_steer_unit;
    logic       clk = 1'b0;
    logic       rst_n, tick, wr_en, pwm_in, period_start, shutdown_evt;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] pin_out;

    always #5 clk = ~clk;

    pwm_steer_unit dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_in(pwm_in),
        .period_start(period_start), .shutdown_evt(shutdown_evt), .pin_out(pin_out));

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [3:0] m_mode = 0, m_act = 4'b0001, m_shadow = 4'b0001, m_port = 0;
    logic [1:0] m_cfg = 0;
    logic [6:0] m_delay = 0;
    logic       m_restart = 0;
    int         m_pend = 0, m_sd = 0, m_run = 0;

    function automatic logic [3:0] exp_pins(input logic p);
        logic [3:0] r;
        logic on, act, low;
        on  = (m_mode[3:2] == 2'b11) && (m_cfg == 2'b00);
        act = p && (m_delay == 0 || m_run >= 4 * m_delay) && (m_sd == 0);
        for (int i = 0; i < 4; i++) begin
            low  = (i % 2 == 0) ? m_mode[1] : m_mode[0];
            r[i] = (on && m_act[i]) ? (act ^ low) : m_port[i];
        end
        return r;
    endfunction

    task automatic cyc(input string tag, input logic p, input logic tk, input logic ps,
                       input logic ev, input logic we, input logic [2:0] a, input logic [7:0] d);
        logic [3:0] e;
        @(negedge clk);
        pwm_in = p; tick = tk; period_start = ps; shutdown_evt = ev;
        wr_en = we; wr_addr = a; wr_data = d;
        #2;
        e = exp_pins(p);
        n_chk++;
        if (pin_out !== e) begin
            n_fail++;
            $display("FAIL %s: pin_out=%b expected=%b at %0t", tag, pin_out, e, $time);
        end
        case (m_sd)
            0: if (ev) m_sd = 1;
            1: if (!ev) m_sd = m_restart ? 0 : 2;
            default: if (ev) m_sd = 1; else if (we && a == 3'd4) m_sd = 0;
        endcase
        if (we && a == 3'd1) begin
            m_shadow = d[3:0]; m_pend = d[4] ? 2 : 1;
        end else if ((m_pend == 1 && tk) || (m_pend == 2 && ps)) begin
            m_act = m_shadow; m_pend = 0;
        end
        if (we && a == 3'd0) begin m_mode = d[3:0]; m_cfg = d[5:4]; end
        if (we && a == 3'd2) begin m_delay = d[6:0]; m_restart = d[7]; end
        if (we && a == 3'd3) m_port = d[3:0];
        m_run = p ? ((m_run < 100000) ? m_run + 1 : m_run) : 0;
    endtask

    task automatic idle(input string tag, input logic p, input int n);
        for (int k = 0; k < n; k++) cyc(tag, p, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input string tag, input logic p, input logic [2:0] a, input logic [7:0] d);
        cyc(tag, p, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed, tcnt;
        logic p;
        seed = 17;
        void'($urandom(seed));
        rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        pwm_in = 0; period_start = 0; shutdown_evt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state, then PWM mode shows mask 0001
        idle("R1", 0, 2); idle("R1", 1, 2);
        wr("R1", 0, 3'd0, 8'h0C);
        idle("R1", 1, 3); idle("R1", 0, 2);
        // R4: non-single configuration or non-PWM mode gives port data
        wr("R4", 0, 3'd3, 8'h0F);
        wr("R4", 0, 3'd0, 8'h1C); idle("R4", 1, 3);
        wr("R4", 1, 3'd0, 8'h08); idle("R4", 0, 3);
        // R2: mask 0101, port 1010
        wr("R2", 0, 3'd3, 8'h0A); wr("R2", 0, 3'd0, 8'h0C);
        wr("R2", 0, 3'd1, 8'h05); cyc("R2", 0, 1, 0, 0, 0, 0, 0);
        idle("R2", 1, 3); idle("R2", 0, 3);
        // R3: polarity per group
        wr("R3", 0, 3'd1, 8'h0F); cyc("R3", 0, 1, 0, 0, 0, 0, 0);
        for (int m = 13; m <= 15; m++) begin
            wr("R3", 0, 3'd0, 8'(m)); idle("R3", 1, 2); idle("R3", 0, 2);
        end
        wr("R3", 0, 3'd0, 8'h0C);
        // R5: immediate mask waits for a tick
        wr("R5", 1, 3'd1, 8'h02); idle("R5", 1, 3);
        cyc("R5", 1, 1, 0, 0, 0, 0, 0); idle("R5", 1, 2);
        // R6: synced mask waits for period start
        wr("R6", 1, 3'd1, 8'h18);
        for (int k = 0; k < 3; k++) cyc("R6", 1, 1, 0, 0, 0, 0, 0);
        cyc("R6", 1, 0, 1, 0, 0, 0, 0); idle("R6", 1, 2); idle("R6", 0, 2);
        wr("R6", 0, 3'd1, 8'h0F); cyc("R6", 0, 1, 0, 0, 0, 0, 0);
        // R7: dead-band of 3 instruction cycles
        wr("R7", 0, 3'd2, 8'h03); idle("R7", 1, 16); idle("R7", 0, 2);
        wr("R7", 0, 3'd2, 8'h05); idle("R7", 1, 24);
        // R8: immediate fall and cancelled short pulse
        idle("R8", 0, 2); idle("R8", 1, 10); idle("R8", 0, 3);
        wr("R8", 0, 3'd2, 8'h00);
        // R9: shutdown with partial mask
        wr("R9", 0, 3'd1, 8'h03); cyc("R9", 0, 1, 0, 0, 0, 0, 0);
        wr("R9", 0, 3'd3, 8'h0C); wr("R9", 0, 3'd0, 8'h0D);
        for (int k = 0; k < 4; k++) cyc("R9", 1, 0, 0, 1, 0, 0, 0);
        // R10: auto restart
        wr("R10", 0, 3'd2, 8'h80);
        for (int k = 0; k < 3; k++) cyc("R10", 1, 0, 0, 1, 0, 0, 0);
        idle("R10", 1, 3);
        // R11: latched until clear, clear during event ignored
        wr("R11", 0, 3'd2, 8'h00);
        cyc("R11", 1, 0, 0, 1, 0, 0, 0); cyc("R11", 1, 0, 0, 1, 1, 3'd4, 8'h00);
        idle("R11", 1, 4); wr("R11", 1, 3'd4, 8'h00); idle("R11", 1, 3);

        // random phase, R2..R11 mixed
        p = 0; tcnt = 0;
        for (int k = 0; k < 4000; k++) begin
            logic we, ev, ps, tk;
            logic [2:0] a;
            logic [7:0] d;
            if ($urandom_range(0, 5) == 0) p = ~p;
            tcnt++; tk = (tcnt % 4 == 0);
            ps = ($urandom_range(0, 19) == 0);
            ev = ($urandom_range(0, 39) == 0) ? 1'b1 : (shutdown_evt && $urandom_range(0, 2) != 0);
            we = ($urandom_range(0, 7) == 0);
            a  = 3'($urandom_range(0, 4));
            d  = 8'($urandom);
            if (a == 3'd0 && $urandom_range(0, 2) != 0) d[5:2] = 4'b0011;
            if (a == 3'd2) begin
                if (p) we = 0;
                d[6:0] = 7'($urandom_range(0, 3));
            end
            cyc("RND", p, tk, ps, ev, we, a, d);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule